// File: doc/BRIEF.md
# Inter-Processor Interrupt Dispatcher

This block lets one CPU in a cluster interrupt other CPUs. A CPU posts a 32-bit command word that names one of sixteen interrupt numbers and picks the receivers. The receivers are chosen by a two-bit mode: an explicit receiver list, every CPU except the poster, the poster alone, or everyone. For each receiver the block stores a vector of the CPUs that have sent that number. A number stays pending on a receiver as long as its vector holds at least one sender.

A receiver acknowledges a number by giving its own CPU index and the number. One cycle later the block returns a reply word. The reply holds the number and the lowest-indexed sender still recorded, and that sender is removed from the vector. An acknowledge that finds no sender returns the spurious code 1023. Software can also add or remove senders in any vector directly, with byte-wide set and clear strobes.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset every sender vector is empty, so `pend_o` is all zero and `ack_valid_o` is low.
- R2: With mode 0 in `post_data[25:24]`, the receivers are the CPUs whose bits are set in `post_data[23:16]`. List bits at or above NUM_CPU are ignored. The number is `post_data[3:0]`, and bits [9:4] of the command are ignored.
- R3: With mode 1, every CPU except `post_cpu` receives the number.
- R4: With mode 2, only `post_cpu` receives the number.
- R5: Mode 3 is reserved and delivers to every CPU.
- R6: A post sets bit `post_cpu` in the sender vector of each receiver for that number. `pend_o[c*NUM_ID+n]` is high in the cycle after any bit of vector (c, n) becomes set.
- R7: An acknowledge raises `ack_valid_o` in the next cycle. When senders exist, `ack_data_o` equals n | (s << 10), where s is the lowest set sender, and bit s is cleared.
- R8: A number remains pending while other senders remain in its vector. It drops when the last sender is acknowledged or cleared.
- R9: An acknowledge on an empty vector returns 1023 and changes no vector.
- R10: `vec_set_we` ORs `vec_data[NUM_CPU-1:0]` into vector (`vec_cpu`, `vec_id`), and `vec_clr_we` removes those bits. A clear that empties the vector drops the pending bit.
- R11: Within one cycle the updates apply in a fixed order: the acknowledge removal first, then the byte clear, then the byte set and the post. A set therefore wins over a removal of the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_we | input | 1 | Command word strobe |
| post_data | input | 32 | Command word: number, receiver list, mode |
| post_cpu | input | CPU_W | Index of the posting CPU |
| vec_set_we | input | 1 | Byte-wide sender set strobe |
| vec_clr_we | input | 1 | Byte-wide sender clear strobe |
| vec_cpu | input | CPU_W | Receiver addressed by set/clear |
| vec_id | input | ID_W | Number addressed by set/clear |
| vec_data | input | 8 | Sender bits to set or clear |
| ack_req | input | 1 | Acknowledge request |
| ack_cpu | input | CPU_W | Acknowledging CPU |
| ack_id | input | ID_W | Number being acknowledged |
| pend_o | output | NUM_CPU*NUM_ID | Pending flag per receiver and number |
| ack_valid_o | output | 1 | Reply valid, one cycle after the request |
| ack_data_o | output | 13 | Reply word: number and sender, or 1023 |

## Verification
`pend_o` is a direct OR of the stored vectors, so a lost or stray sender bit usually shows as a wrong pending flag in the very next cycle. One case does not show there: a corrupted sender bit in a vector that still holds another sender. That error appears only when the receiver acknowledges, either as a wrong sender field in the reply or as a pending flag that outlives its last real sender. The bench therefore drains vectors with repeated acknowledges, and it compares the flags and the replies against a behavioural model every cycle.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_ALL    = 2'd3
    } ipi_filter_e;

    localparam int ACK_W      = 13;
    localparam int SRC_LSB    = 10;
    localparam int SRC_W      = 3;
    localparam int FILTER_LSB = 24;
    localparam int LIST_LSB   = 16;
    localparam int LIST_W     = 8;
    localparam logic [ACK_W-1:0] ACK_NONE = 13'd1023;
endpackage

// File: rtl/ipi_target_decode.sv
module ipi_target_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = $clog2(NUM_CPU)
) (
    input  ipi_filter_e         filter,
    input  logic [LIST_W-1:0]   list,
    input  logic [CPU_W-1:0]    writer,
    output logic [NUM_CPU-1:0]  mask
);
    localparam logic [NUM_CPU-1:0] ALL_CPUS = {NUM_CPU{1'b1}};

    logic [NUM_CPU-1:0] self_bit;
    assign self_bit = NUM_CPU'(1) << writer;

    always_comb begin
        case (filter)
            FLT_LIST:   mask = list[NUM_CPU-1:0];
            FLT_OTHERS: mask = ALL_CPUS & ~self_bit;
            FLT_SELF:   mask = self_bit;
            default:    mask = ALL_CPUS;
        endcase
    end

    always_comb begin
        if (filter == FLT_SELF) begin
            AST_SELF_ONLY: assert ($countones(mask) == 1 && mask[writer]); // R4
        end
        if (filter == FLT_OTHERS) begin
            AST_OTHERS_SKIP_WRITER: assert (!mask[writer] && $countones(mask) == NUM_CPU - 1); // R3
        end
    end
endmodule

// File: rtl/ipi_src_pick.sv
module ipi_src_pick #(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = $clog2(NUM_CPU)
) (
    input  logic [NUM_CPU-1:0] vec,
    output logic               found,
    output logic [CPU_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CPU - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = CPU_W'(i);
            end
        end
    end

    always_comb begin
        if (found) begin
            AST_LOWEST_SOURCE: assert (vec[idx] && $countones(vec & ~({NUM_CPU{1'b1}} << idx)) == 0); // R7
        end else begin
            AST_EMPTY_VECTOR: assert (vec == '0); // R9
        end
    end
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_ID  = 16,
    localparam int CPU_W  = $clog2(NUM_CPU),
    localparam int ID_W   = $clog2(NUM_ID),
    localparam int SLOT_W = $clog2(NUM_CPU * NUM_ID)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      post_we,
    input  logic [31:0]               post_data,
    input  logic [CPU_W-1:0]          post_cpu,
    input  logic                      vec_set_we,
    input  logic                      vec_clr_we,
    input  logic [CPU_W-1:0]          vec_cpu,
    input  logic [ID_W-1:0]           vec_id,
    input  logic [7:0]                vec_data,
    input  logic                      ack_req,
    input  logic [CPU_W-1:0]          ack_cpu,
    input  logic [ID_W-1:0]           ack_id,
    output logic [NUM_CPU*NUM_ID-1:0] pend_o,
    output logic                      ack_valid_o,
    output logic [ACK_W-1:0]          ack_data_o
);
    typedef struct packed {
        logic [NUM_CPU-1:0][NUM_ID-1:0][NUM_CPU-1:0] vec;
        logic                                        ack_valid;
        logic [ACK_W-1:0]                            ack_data;
    } state_t;

    state_t state_d, state_q;

    ipi_filter_e        post_filter;
    logic [ID_W-1:0]    post_id;
    logic [NUM_CPU-1:0] tgt_mask;
    logic [NUM_CPU-1:0] ack_vec;
    logic               ack_found;
    logic [CPU_W-1:0]   ack_src;
    logic [SLOT_W-1:0]  ack_slot;
    logic [SLOT_W-1:0]  self_slot;
    logic               unused_post_bits;

    assign post_filter      = ipi_filter_e'(post_data[FILTER_LSB +: 2]);
    assign post_id          = post_data[ID_W-1:0];
    assign unused_post_bits = ^{post_data[31:FILTER_LSB+2], post_data[LIST_LSB-1:ID_W], vec_data};
    assign ack_vec          = state_q.vec[ack_cpu][ack_id];
    assign ack_slot         = SLOT_W'(int'(ack_cpu) * NUM_ID + int'(ack_id));
    assign self_slot        = SLOT_W'(int'(post_cpu) * NUM_ID + int'(post_id));

    ipi_target_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) i_decode (
        .filter (post_filter),
        .list   (post_data[LIST_LSB +: LIST_W]),
        .writer (post_cpu),
        .mask   (tgt_mask)
    );

    ipi_src_pick #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) i_pick (
        .vec   (ack_vec),
        .found (ack_found),
        .idx   (ack_src)
    );

    always_comb begin
        state_d           = state_q;
        state_d.ack_valid = ack_req;
        state_d.ack_data  = '0;
        // acknowledge removal comes first
        if (ack_req) begin
            if (ack_found) begin
                state_d.ack_data[ID_W-1:0]         = ack_id;
                state_d.ack_data[SRC_LSB +: SRC_W] = SRC_W'(ack_src);
                state_d.vec[ack_cpu][ack_id][ack_src] = 1'b0;
            end else begin
                state_d.ack_data = ACK_NONE;
            end
        end
        // then byte clear, then the set paths so that a set wins
        if (vec_clr_we) begin
            state_d.vec[vec_cpu][vec_id] = state_d.vec[vec_cpu][vec_id] & ~vec_data[NUM_CPU-1:0];
        end
        if (vec_set_we) begin
            state_d.vec[vec_cpu][vec_id] = state_d.vec[vec_cpu][vec_id] | vec_data[NUM_CPU-1:0];
        end
        if (post_we) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                if (tgt_mask[c]) begin
                    state_d.vec[c][post_id][post_cpu] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar n = 0; n < NUM_ID; n++) begin : g_id
            assign pend_o[c*NUM_ID + n] = |state_q.vec[c][n];
        end
    end

    assign ack_valid_o = state_q.ack_valid;
    assign ack_data_o  = state_q.ack_data;

    AST_ACK_REPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid_o); // R7
    AST_SPURIOUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_found) |=> (ack_data_o == ACK_NONE)); // R9
    AST_SPURIOUS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_found && !vec_set_we && !vec_clr_we && !post_we) |=> $stable(state_q.vec)); // R9
    AST_LAST_SOURCE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_found && $countones(ack_vec) == 1 && !vec_set_we && !post_we)
        |=> !pend_o[$past(ack_slot)]); // R8
    AST_SELF_POST_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (post_we && post_filter == FLT_SELF) |=> pend_o[$past(self_slot)]); // R11
endmodule

// File: tb/test_ipi_dispatch.sv
module test_ipi_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;
    localparam int NID  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              post_we = 1'b0;
    logic [31:0]       post_data = '0;
    logic [1:0]        post_cpu = '0;
    logic              vec_set_we = 1'b0;
    logic              vec_clr_we = 1'b0;
    logic [1:0]        vec_cpu = '0;
    logic [3:0]        vec_id = '0;
    logic [7:0]        vec_data = '0;
    logic              ack_req = 1'b0;
    logic [1:0]        ack_cpu = '0;
    logic [3:0]        ack_id = '0;
    logic [NCPU*NID-1:0] pend_o;
    logic              ack_valid_o;
    logic [12:0]       ack_data_o;

    int checks = 0;
    int fails  = 0;

    bit [NCPU-1:0] m [NCPU][NID];
    bit            exp_valid;
    int            exp_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_dispatch #(.NUM_CPU(NCPU), .NUM_ID(NID)) i_ipi_dispatch (
        .clk, .rst_n, .post_we, .post_data, .post_cpu,
        .vec_set_we, .vec_clr_we, .vec_cpu, .vec_id, .vec_data,
        .ack_req, .ack_cpu, .ack_id, .pend_o, .ack_valid_o, .ack_data_o
    );

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        post_we = 0; vec_set_we = 0; vec_clr_we = 0; ack_req = 0;
    endtask

    // behavioural model: receiver set per mode
    function automatic bit [NCPU-1:0] receivers(bit [31:0] d, int w);
        bit [NCPU-1:0] r = '0;
        for (int c = 0; c < NCPU; c++) begin
            case (d[25:24])
                2'd0: r[c] = d[16+c];
                2'd1: r[c] = (c != w);
                2'd2: r[c] = (c == w);
                default: r[c] = 1'b1;
            endcase
        end
        return r;
    endfunction

    task automatic tick(string tag);
        bit [NCPU-1:0] tg;
        bit [NCPU*NID-1:0] ep;
        exp_valid = ack_req;
        if (ack_req) begin
            if (m[ack_cpu][ack_id] == 0) exp_data = 1023;
            else begin
                int s = 0;
                while (!m[ack_cpu][ack_id][s]) s++;
                exp_data = int'(ack_id) + (s << 10);
                m[ack_cpu][ack_id][s] = 0;
            end
        end
        if (vec_clr_we) m[vec_cpu][vec_id] &= ~vec_data[NCPU-1:0];
        if (vec_set_we) m[vec_cpu][vec_id] |= vec_data[NCPU-1:0];
        if (post_we) begin
            tg = receivers(post_data, post_cpu);
            for (int c = 0; c < NCPU; c++)
                if (tg[c]) m[c][post_data[3:0]][post_cpu] = 1;
        end
        @(posedge clk);
        #1;
        for (int c = 0; c < NCPU; c++)
            for (int n = 0; n < NID; n++)
                ep[c*NID+n] = (m[c][n] != 0);
        check(tag, "pend_o", pend_o, ep);
        check(tag, "ack_valid_o", ack_valid_o, exp_valid);
        if (exp_valid) check(tag, "ack_data_o", ack_data_o, exp_data);
        idle();
    endtask

    task automatic post(int w, int mode, int list, int word_id);
        post_we = 1; post_cpu = 2'(w);
        post_data = (32'(mode) << 24) | (32'(list) << 16) | 32'(word_id);
    endtask

    task automatic ack(int c, int n);
        ack_req = 1; ack_cpu = 2'(c); ack_id = 4'(n);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCPU; c++)
            for (int n = 0; n < NID; n++) m[c][n] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        check("R1", "pend_o", pend_o, 0);
        check("R1", "ack_valid_o", ack_valid_o, 0);

        // R2: list mode, junk in id bits [9:4] and in list bits above the CPUs
        post(1, 0, 'hF5, 'h3F5); tick("R2");
        check("R2", "pend cpu2 id5", pend_o[2*NID+5], 1);
        check("R2", "pend cpu1 id5", pend_o[1*NID+5], 0);
        // R3 / R4 / R5
        post(2, 1, 0, 7); tick("R3");
        check("R3", "pend cpu2 id7", pend_o[2*NID+7], 0);
        post(3, 2, 'hFF, 15); tick("R4");
        check("R4", "pend cpu3 id15", pend_o[3*NID+15], 1);
        post(0, 3, 0, 0); tick("R5");
        // R6 + R8: a second sender on cpu0 id5, drain it
        post(3, 0, 'h01, 5); tick("R6");
        ack(0, 5); tick("R7");
        check("R7", "reply sender1", ack_data_o, 5 | (1 << 10));
        check("R8", "still pending", pend_o[0*NID+5], 1);
        ack(0, 5); tick("R8");
        check("R8", "reply sender3", ack_data_o, 5 | (3 << 10));
        check("R8", "dropped", pend_o[0*NID+5], 0);
        ack(0, 5); tick("R9");
        check("R9", "spurious", ack_data_o, 1023);
        // R10: byte set and clear
        vec_set_we = 1; vec_cpu = 2; vec_id = 9; vec_data = 'hFA; tick("R10");
        vec_clr_we = 1; vec_cpu = 2; vec_id = 9; vec_data = 'h02; tick("R10");
        check("R10", "pending after partial clear", pend_o[2*NID+9], 1);
        vec_clr_we = 1; vec_cpu = 2; vec_id = 9; vec_data = 'h08; tick("R10");
        check("R10", "cleared", pend_o[2*NID+9], 0);
        // R11: same-cycle set wins over clear and over acknowledge removal
        vec_set_we = 1; vec_clr_we = 1; vec_cpu = 1; vec_id = 4; vec_data = 'h04; tick("R11");
        check("R11", "set beats clear", pend_o[1*NID+4], 1);
        ack(1, 4); post(2, 2, 0, 4); tick("R11");
        check("R11", "reply", ack_data_o, 4 | (2 << 10));
        check("R11", "re-posted", pend_o[1*NID+4], 0);
        ack(2, 4); post(2, 2, 0, 4); tick("R11");
        check("R11", "ack then re-post keeps pending", pend_o[2*NID+4], 1);

        // mixed traffic against the model
        for (int k = 0; k < 600; k++) begin
            int r = $urandom;
            int q = $urandom;
            post_we = (r[2:0] == 0); post_cpu = 2'(r[4:3]); post_data = q;
            vec_set_we = (r[7:5] == 0); vec_clr_we = (r[10:8] == 0);
            vec_cpu = 2'(r[12:11]); vec_id = 4'(r[16:13]); vec_data = 8'(r[24:17]);
            ack_req = r[25]; ack_cpu = 2'(r[27:26]); ack_id = 4'(q[31:28] ^ r[31:28]);
            tick("R11");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule